// File: doc/BRIEF.md
# Coincident-Current Core Store Access Sequencer

This block runs a coincident-current magnetic core store of 32K words of 9 bits. A client raises a request with a 15-bit address, a write flag and a 9-bit data word. The block captures the request and splits the address into several tiers of drive selection: secondary and primary selector enables for each axis, a one-of-four quadrant diode enable, a stack enable and an upper/lower half-stack inhibit select. It then steps the store through a fixed access cycle.

Reading a core destroys its contents. For this reason every access starts with a read phase that drives read current on both axes and strobes the sense inputs. A write phase always follows. In that phase the sensed word is restored, or the new word is written if the request was a write. During the write phase a bit's inhibit enable is raised only when that bit is to end up zero. The sensed word is returned on `rd_data`, and a one-cycle `done` marks the end of the access. The analog drivers, the sense amplifiers and the array itself sit outside this block.

Top module: `core_cycle_seq`

## Requirements
- R1: `ready` is high only while the sequencer is idle. A request is taken on a rising edge where both `req` and `ready` are high. A request held while `ready` is low has no effect: it writes nothing and produces no extra `done`.
- R2: While the drive lines are on, the address fields select one-hot enables. `x_sec_en` bit addr[1:0], `y_sec_en` bit addr[3:2], `x_pri_en` bit addr[6:4], `y_pri_en` bit addr[9:7] and `stack_en` bit addr[13:12] are set, and no other bit in these groups.
- R3: The quadrant addr[11:10] selects bit addr[11:10] of `diode_rd_en` during the read and strobe phases, and the same bit of `diode_wr_en` during the write phase. The read and write diode enables are never both non-zero.
- R4: After the accepting edge, the read drive lasts READ_CYC cycles, the sense strobe lasts 1 cycle, the write drive lasts WRITE_CYC cycles and recovery lasts RECOVER_CYC cycles.
- R5: `sense_strobe` is high for exactly the strobe cycle. `sense_in` is captured at the end of that cycle, and from then on `rd_data` holds the captured word until the next strobe.
- R6: On a read request (`req_we` = 0), the write phase writes back the sensed word.
- R7: On a write request (`req_we` = 1), the write phase writes `req_wdata`, and `rd_data` returns the word that was in the location before the write.
- R8: During the write phase, `bit_inh_en[i]` is high exactly when bit i of the word being written is 0. Outside the write phase it is all zero.
- R9: During the write phase, `half_inh_en` is 2'b10 when addr[14] is 1 (upper half) and 2'b01 when it is 0 (lower half). Outside the write phase it is 2'b00.
- R10: While idle and during recovery, every drive, diode, stack and inhibit enable is zero.
- R11: `done` is high for exactly one cycle: the first idle cycle after recovery ends.
- R12: After reset, `ready` is 1 and `done`, `sense_strobe`, `rd_data` and all enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request |
| req_we | input | 1 | 1 = write new data, 0 = read and restore |
| req_addr | input | 15 | Word address |
| req_wdata | input | 9 | Data for a write request |
| ready | output | 1 | Idle, request may be taken |
| x_sec_en | output | 4 | X secondary selector enables |
| y_sec_en | output | 4 | Y secondary selector enables |
| x_pri_en | output | 8 | X primary selector enables |
| y_pri_en | output | 8 | Y primary selector enables |
| diode_rd_en | output | 4 | Read-line diode enable per quadrant |
| diode_wr_en | output | 4 | Write-line diode enable per quadrant |
| stack_en | output | 4 | Stack enables |
| half_inh_en | output | 2 | Half-stack inhibit select, bit 1 upper, bit 0 lower |
| bit_inh_en | output | 9 | Per-bit inhibit enables |
| sense_strobe | output | 1 | Sense strobe cycle |
| sense_in | input | 9 | Sense amplifier outputs |
| rd_data | output | 9 | Word sensed in the last access |
| done | output | 1 | One-cycle end-of-access pulse |

## Verification
With the default phase lengths of 3, 3 and 2, an accepting edge is followed by the read drive in cycles 1 to 3, the strobe in cycle 4, the write drive in cycles 5 to 7 and recovery in cycles 8 and 9. `done` appears in cycle 10, and `rd_data` carries the sensed word from cycle 5. The bench counts falling edges from the accepting rising edge and compares each output only in the cycle where the requirement places it. The array is modelled behaviourally from the enables on falling edges: a strobe clears the word, and a write drive stores the complement of the inhibit bits. Restore, write-through and the ignored busy request can therefore all be confirmed by reading the location back through a later access.

// File: rtl/core_seq_pkg.sv
package core_seq_pkg;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_READ,
      PH_STROBE,
      PH_WRITE,
      PH_RECOVER
   } phase_t;

endpackage

// File: rtl/core_onehot.sv
// Gated one-hot selector: output bit sel is set when en is high.
module core_onehot #(
   parameter int IN_W = 2,
   localparam int OUT_N = 1 << IN_W
) (
   input  logic [IN_W-1:0]  sel,
   input  logic             en,
   output logic [OUT_N-1:0] oh
);

   for (genvar i = 0; i < OUT_N; i++) begin : g_bit
      assign oh[i] = en && (sel == IN_W'(i));
   end

endmodule

// File: rtl/core_addr_decode.sv
// Splits the latched address into the drive-selection tiers.
module core_addr_decode #(
   parameter int XS_W = 2,
   parameter int YS_W = 2,
   parameter int XP_W = 3,
   parameter int YP_W = 3,
   parameter int QD_W = 2,
   parameter int ST_W = 2,
   localparam int ADDR_W = XS_W + YS_W + XP_W + YP_W + QD_W + ST_W + 1,
   localparam int YS_LO  = XS_W,
   localparam int XP_LO  = YS_LO + YS_W,
   localparam int YP_LO  = XP_LO + XP_W,
   localparam int QD_LO  = YP_LO + YP_W,
   localparam int ST_LO  = QD_LO + QD_W,
   localparam int HF_BIT = ST_LO + ST_W
) (
   input  logic [ADDR_W-1:0]    addr,
   input  logic                 rd_on,
   input  logic                 wr_on,
   output logic [(1<<XS_W)-1:0] x_sec_en,
   output logic [(1<<YS_W)-1:0] y_sec_en,
   output logic [(1<<XP_W)-1:0] x_pri_en,
   output logic [(1<<YP_W)-1:0] y_pri_en,
   output logic [(1<<QD_W)-1:0] diode_rd_en,
   output logic [(1<<QD_W)-1:0] diode_wr_en,
   output logic [(1<<ST_W)-1:0] stack_en,
   output logic [1:0]           half_inh_en
);

   logic drive_on;
   assign drive_on = rd_on | wr_on;

   core_onehot #(.IN_W(XS_W)) u_xs (.sel(addr[XS_W-1:0]),          .en(drive_on), .oh(x_sec_en));
   core_onehot #(.IN_W(YS_W)) u_ys (.sel(addr[YS_LO +: YS_W]),     .en(drive_on), .oh(y_sec_en));
   core_onehot #(.IN_W(XP_W)) u_xp (.sel(addr[XP_LO +: XP_W]),     .en(drive_on), .oh(x_pri_en));
   core_onehot #(.IN_W(YP_W)) u_yp (.sel(addr[YP_LO +: YP_W]),     .en(drive_on), .oh(y_pri_en));
   core_onehot #(.IN_W(QD_W)) u_qr (.sel(addr[QD_LO +: QD_W]),     .en(rd_on),    .oh(diode_rd_en));
   core_onehot #(.IN_W(QD_W)) u_qw (.sel(addr[QD_LO +: QD_W]),     .en(wr_on),    .oh(diode_wr_en));
   core_onehot #(.IN_W(ST_W)) u_st (.sel(addr[ST_LO +: ST_W]),     .en(drive_on), .oh(stack_en));
   core_onehot #(.IN_W(1))    u_hf (.sel(addr[HF_BIT +: 1]),       .en(wr_on),    .oh(half_inh_en));

endmodule

// File: rtl/core_phase_fsm.sv
// Access phase sequencer with per-phase cycle counters.
module core_phase_fsm
   import core_seq_pkg::*;
#(
   parameter int READ_CYC    = 3,
   parameter int WRITE_CYC   = 3,
   parameter int RECOVER_CYC = 2,
   localparam int MAX_CYC = (READ_CYC > WRITE_CYC)
                            ? ((READ_CYC > RECOVER_CYC) ? READ_CYC : RECOVER_CYC)
                            : ((WRITE_CYC > RECOVER_CYC) ? WRITE_CYC : RECOVER_CYC),
   localparam int CNT_W = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   output logic ready,
   output logic accept,
   output logic rd_on,
   output logic wr_on,
   output logic strobe,
   output logic done
);

   phase_t     phase_q;
   logic [CNT_W-1:0] cnt_q;
   logic       last;

   assign ready  = (phase_q == PH_IDLE);
   assign accept = ready && req;
   assign rd_on  = (phase_q == PH_READ) || (phase_q == PH_STROBE);
   assign wr_on  = (phase_q == PH_WRITE);
   assign strobe = (phase_q == PH_STROBE);
   assign last   = (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         cnt_q   <= '0;
         done    <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (phase_q)
            PH_IDLE: if (req) begin
               phase_q <= PH_READ;
               cnt_q   <= CNT_W'(READ_CYC - 1);
            end
            PH_READ: begin
               if (last) phase_q <= PH_STROBE;
               else      cnt_q   <= cnt_q - 1'b1;
            end
            PH_STROBE: begin
               phase_q <= PH_WRITE;
               cnt_q   <= CNT_W'(WRITE_CYC - 1);
            end
            PH_WRITE: begin
               if (last) begin
                  phase_q <= PH_RECOVER;
                  cnt_q   <= CNT_W'(RECOVER_CYC - 1);
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            PH_RECOVER: begin
               if (last) begin
                  phase_q <= PH_IDLE;
                  done    <= 1'b1;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            default: phase_q <= PH_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/core_data_path.sv
// Sense capture, write/restore word select and inhibit generation.
module core_data_path #(
   parameter int DATA_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic              req_we,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              strobe,
   input  logic              wr_on,
   input  logic [DATA_W-1:0] sense_in,
   output logic [DATA_W-1:0] rd_data,
   output logic [DATA_W-1:0] bit_inh_en
);

   logic              we_q;
   logic [DATA_W-1:0] wdata_q;
   logic [DATA_W-1:0] word;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         we_q    <= 1'b0;
         wdata_q <= '0;
         rd_data <= '0;
      end else begin
         if (accept) begin
            we_q    <= req_we;
            wdata_q <= req_wdata;
         end
         if (strobe) rd_data <= sense_in;
      end
   end

   assign word = we_q ? wdata_q : rd_data;

   for (genvar b = 0; b < DATA_W; b++) begin : g_inh
      assign bit_inh_en[b] = wr_on && !word[b];
   end

endmodule

// File: rtl/core_cycle_seq.sv
module core_cycle_seq #(
   parameter int XS_W        = 2,
   parameter int YS_W        = 2,
   parameter int XP_W        = 3,
   parameter int YP_W        = 3,
   parameter int QD_W        = 2,
   parameter int ST_W        = 2,
   parameter int DATA_W      = 9,
   parameter int READ_CYC    = 3,
   parameter int WRITE_CYC   = 3,
   parameter int RECOVER_CYC = 2,
   localparam int ADDR_W = XS_W + YS_W + XP_W + YP_W + QD_W + ST_W + 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req,
   input  logic                 req_we,
   input  logic [ADDR_W-1:0]    req_addr,
   input  logic [DATA_W-1:0]    req_wdata,
   output logic                 ready,
   output logic [(1<<XS_W)-1:0] x_sec_en,
   output logic [(1<<YS_W)-1:0] y_sec_en,
   output logic [(1<<XP_W)-1:0] x_pri_en,
   output logic [(1<<YP_W)-1:0] y_pri_en,
   output logic [(1<<QD_W)-1:0] diode_rd_en,
   output logic [(1<<QD_W)-1:0] diode_wr_en,
   output logic [(1<<ST_W)-1:0] stack_en,
   output logic [1:0]           half_inh_en,
   output logic [DATA_W-1:0]    bit_inh_en,
   output logic                 sense_strobe,
   input  logic [DATA_W-1:0]    sense_in,
   output logic [DATA_W-1:0]    rd_data,
   output logic                 done
);

   if (QD_W != 2) begin : g_bad_quad
      $error("quadrant field must select one of four");
   end
   if (READ_CYC < 1 || WRITE_CYC < 1 || RECOVER_CYC < 1) begin : g_bad_len
      $error("every phase needs at least one cycle");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("data width must be positive");
   end

   logic              accept;
   logic              rd_on;
   logic              wr_on;
   logic [ADDR_W-1:0] addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      addr_q <= '0;
      else if (accept) addr_q <= req_addr;
   end

   core_phase_fsm #(
      .READ_CYC(READ_CYC), .WRITE_CYC(WRITE_CYC), .RECOVER_CYC(RECOVER_CYC)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n), .req(req), .ready(ready), .accept(accept),
      .rd_on(rd_on), .wr_on(wr_on), .strobe(sense_strobe), .done(done)
   );

   core_addr_decode #(
      .XS_W(XS_W), .YS_W(YS_W), .XP_W(XP_W), .YP_W(YP_W), .QD_W(QD_W), .ST_W(ST_W)
   ) u_dec (
      .addr(addr_q), .rd_on(rd_on), .wr_on(wr_on),
      .x_sec_en(x_sec_en), .y_sec_en(y_sec_en), .x_pri_en(x_pri_en), .y_pri_en(y_pri_en),
      .diode_rd_en(diode_rd_en), .diode_wr_en(diode_wr_en),
      .stack_en(stack_en), .half_inh_en(half_inh_en)
   );

   core_data_path #(.DATA_W(DATA_W)) u_dp (
      .clk(clk), .rst_n(rst_n), .accept(accept), .req_we(req_we), .req_wdata(req_wdata),
      .strobe(sense_strobe), .wr_on(wr_on), .sense_in(sense_in),
      .rd_data(rd_data), .bit_inh_en(bit_inh_en)
   );

endmodule

// File: rtl/core_cycle_seq_chk.sv
module core_cycle_seq_chk #(
   parameter int XN = 4, parameter int YN = 4, parameter int XPN = 8, parameter int YPN = 8,
   parameter int QN = 4, parameter int SN = 4, parameter int DATA_W = 9
) (
   input logic           clk,
   input logic           rst_n,
   input logic           req,
   input logic           ready,
   input logic [XN-1:0]  x_sec_en,
   input logic [YN-1:0]  y_sec_en,
   input logic [XPN-1:0] x_pri_en,
   input logic [YPN-1:0] y_pri_en,
   input logic [QN-1:0]  diode_rd_en,
   input logic [QN-1:0]  diode_wr_en,
   input logic [SN-1:0]  stack_en,
   input logic [1:0]     half_inh_en,
   input logic [DATA_W-1:0] bit_inh_en,
   input logic           sense_strobe,
   input logic           done
);

   assert_accept_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (req && ready) |=> !ready);

   assert_onehot_groups_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(x_sec_en) && $onehot0(y_sec_en) && $onehot0(x_pri_en)
      && $onehot0(y_pri_en) && $onehot0(stack_en));

   assert_diode_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !((|diode_rd_en) && (|diode_wr_en)));

   assert_strobe_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
      sense_strobe |-> $onehot(diode_rd_en));

   assert_inh_only_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (|bit_inh_en) |-> (|diode_wr_en));

   assert_half_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (|diode_wr_en) |-> $onehot(half_inh_en));

   assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> (x_sec_en == '0 && y_sec_en == '0 && x_pri_en == '0 && y_pri_en == '0
                 && diode_rd_en == '0 && diode_wr_en == '0 && stack_en == '0
                 && half_inh_en == '0 && bit_inh_en == '0));

   assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ready);

endmodule

bind core_cycle_seq core_cycle_seq_chk #(
   .XN(1 << XS_W), .YN(1 << YS_W), .XPN(1 << XP_W), .YPN(1 << YP_W),
   .QN(1 << QD_W), .SN(1 << ST_W), .DATA_W(DATA_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req(req), .ready(ready),
   .x_sec_en(x_sec_en), .y_sec_en(y_sec_en), .x_pri_en(x_pri_en), .y_pri_en(y_pri_en),
   .diode_rd_en(diode_rd_en), .diode_wr_en(diode_wr_en), .stack_en(stack_en),
   .half_inh_en(half_inh_en), .bit_inh_en(bit_inh_en),
   .sense_strobe(sense_strobe), .done(done)
);

// File: tb/core_cycle_seq_tb.sv
module core_cycle_seq_tb;

   localparam int RD = 3, WR = 3, RC = 2;
   localparam int DONE_N = RD + WR + RC + 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req = 1'b0, req_we = 1'b0;
   logic [14:0] req_addr = '0;
   logic [8:0] req_wdata = '0;
   logic       ready, sense_strobe, done;
   logic [3:0] x_sec_en, y_sec_en, diode_rd_en, diode_wr_en, stack_en;
   logic [7:0] x_pri_en, y_pri_en;
   logic [1:0] half_inh_en;
   logic [8:0] bit_inh_en, rd_data;
   logic [8:0] sense_in = '0;

   int n_chk = 0, n_bad = 0, cyc = 0;
   logic cur_half = 1'b0;
   logic [8:0] mem [int];

   always #10 clk = ~clk;

   core_cycle_seq #(.READ_CYC(RD), .WRITE_CYC(WR), .RECOVER_CYC(RC)) u_dut (
      .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we), .req_addr(req_addr),
      .req_wdata(req_wdata), .ready(ready), .x_sec_en(x_sec_en), .y_sec_en(y_sec_en),
      .x_pri_en(x_pri_en), .y_pri_en(y_pri_en), .diode_rd_en(diode_rd_en),
      .diode_wr_en(diode_wr_en), .stack_en(stack_en), .half_inh_en(half_inh_en),
      .bit_inh_en(bit_inh_en), .sense_strobe(sense_strobe), .sense_in(sense_in),
      .rd_data(rd_data), .done(done)
   );

   function automatic int oh_idx(input logic [7:0] v);
      int r = -1;
      for (int i = 0; i < 8; i++) if (v[i]) r = (r == -1) ? i : -2;
      return r;
   endfunction

   function automatic logic [8:0] peek(input int a);
      return mem.exists(a) ? mem[a] : 9'h0;
   endfunction

   function automatic int cell_addr(input logic [3:0] quad, input logic half);
      return {half, 2'(oh_idx({4'h0, stack_en})), 2'(oh_idx({4'h0, quad})),
              3'(oh_idx(y_pri_en)), 3'(oh_idx(x_pri_en)),
              2'(oh_idx({4'h0, y_sec_en})), 2'(oh_idx({4'h0, x_sec_en}))};
   endfunction

   // behavioural array: a strobe empties the cell, a write drive stores ~inhibit
   always @(negedge clk) begin
      if (sense_strobe) begin
         sense_in <= peek(cell_addr(diode_rd_en, cur_half));
         mem[cell_addr(diode_rd_en, cur_half)] = 9'h0;
      end else if (|diode_rd_en) begin
         sense_in <= peek(cell_addr(diode_rd_en, cur_half));
      end else begin
         sense_in <= 9'h0;
      end
      if (|diode_wr_en)
         mem[cell_addr(diode_wr_en, half_inh_en[1])] = ~bit_inh_en;
   end

   task automatic chk(input bit ok, input string rq, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
      end
   endtask

   function automatic bit all_off();
      return x_sec_en == 0 && y_sec_en == 0 && x_pri_en == 0 && y_pri_en == 0 &&
             diode_rd_en == 0 && diode_wr_en == 0 && stack_en == 0 &&
             half_inh_en == 0 && bit_inh_en == 0;
   endfunction

   // one access; checks every phase at its expected cycle
   task automatic access(input bit we, input logic [14:0] a, input logic [8:0] wd,
                         input logic [8:0] old, input bit poke);
      logic [8:0] word;
      word = we ? wd : old;
      @(negedge clk);
      req = 1; req_we = we; req_addr = a; req_wdata = wd; cur_half = a[14];
      @(posedge clk);
      for (int n = 1; n <= DONE_N + 1; n++) begin
         @(negedge clk);
         if (n == 1) begin
            req = 0;
            chk(x_sec_en == 4'(1 << a[1:0]) && y_sec_en == 4'(1 << a[3:2]) &&
                x_pri_en == 8'(1 << a[6:4]) && y_pri_en == 8'(1 << a[9:7]) &&
                stack_en == 4'(1 << a[13:12]), "R2", {x_pri_en, y_pri_en}, a);
            chk(diode_rd_en == 4'(1 << a[11:10]) && diode_wr_en == 0, "R3 read",
                diode_rd_en, 4'(1 << a[11:10]));
            chk(half_inh_en == 0 && bit_inh_en == 0, "R8 R9 no inhibit in read",
                {half_inh_en, bit_inh_en}, 0);
         end
         if (poke && n == 2) begin
            req = 1; req_we = 1; req_addr = a ^ 15'h0155; req_wdata = 9'h1a5;
         end
         if (poke && n >= 2 && n < DONE_N) chk(ready == 0, "R1 busy", ready, 0);
         if (poke && n == DONE_N - 1) req = 0;
         if (n <= RD) chk(sense_strobe == 0, "R4 read drive", sense_strobe, 0);
         if (n == RD + 1) chk(sense_strobe == 1 && diode_rd_en != 0, "R5 strobe",
                              sense_strobe, 1);
         if (n == RD + 2) begin
            chk(rd_data == old, we ? "R7 old word" : "R5 sensed", rd_data, old);
            chk(diode_wr_en == 4'(1 << a[11:10]) && diode_rd_en == 0, "R3 write",
                diode_wr_en, 4'(1 << a[11:10]));
            chk(bit_inh_en == ~word, "R8 inhibit", bit_inh_en, ~word);
            chk(half_inh_en == (a[14] ? 2'b10 : 2'b01), "R9 half", half_inh_en,
                a[14] ? 2 : 1);
         end
         if (n == RD + WR + 1) chk(diode_wr_en != 0 && done == 0, "R4 write end",
                                   diode_wr_en, 4'(1 << a[11:10]));
         if (n == RD + WR + 2 || n == RD + WR + RC + 1)
            chk(all_off() && ready == 0 && done == 0, "R10 recover", ready, 0);
         if (n == DONE_N) chk(done == 1 && ready == 1 && all_off(), "R11 done", done, 1);
         if (n == DONE_N + 1) chk(done == 0, "R11 one cycle", done, 0);
      end
   endtask

   task automatic t_reset();
      chk(ready == 1 && done == 0 && sense_strobe == 0 && rd_data == 0 && all_off(),
          "R12 reset", {ready, done, rd_data}, 9'h0 | (1 << 10));
   endtask

   task automatic t_write_then_read();
      access(1, 15'h4abc, 9'h15a, 9'h000, 0);          // R7
      access(0, 15'h4abc, 9'h000, 9'h15a, 0);          // R6 restore
      access(0, 15'h4abc, 9'h000, 9'h15a, 0);          // still present after restore
   endtask

   task automatic t_overwrite_lower();
      access(1, 15'h0123, 9'h1ff, 9'h000, 0);
      access(1, 15'h0123, 9'h000, 9'h1ff, 0);          // R7 returns previous
      access(0, 15'h0123, 9'h000, 9'h000, 0);
   endtask

   task automatic t_busy_ignored();
      access(1, 15'h7001, 9'h0c3, 9'h000, 1);
      repeat (3) begin
         @(negedge clk);
         chk(done == 0 && ready == 1, "R1 no extra access", done, 0);
      end
      access(0, 15'h7001 ^ 15'h0155, 9'h000, 9'h000, 0); // R1 target untouched
      access(0, 15'h7001, 9'h000, 9'h0c3, 0);
   endtask

   task automatic t_corners();
      access(1, 15'h7fff, 9'h101, 9'h000, 0);
      access(1, 15'h0000, 9'h0fe, 9'h000, 0);
      access(0, 15'h7fff, 9'h000, 9'h101, 0);
      access(0, 15'h0000, 9'h000, 9'h0fe, 0);
      access(0, 15'h3fff, 9'h000, 9'h000, 0);          // other half of 7fff
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual %0d expected < 20000", cyc);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_write_then_read();
      t_overwrite_lower();
      t_busy_ignored();
      t_corners();
      repeat (2) @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule